// File: doc/BRIEF.md
# Lifecycle escalation and broadcast controller

This block holds the device lifecycle state and turns it into a set of enable lines for debug, test, CPU, key and secret-storage logic elsewhere in the chip. The state and a transition counter are loaded from the non-volatile memory controller on the first clock edge after reset. A tiered escalation input from the alert handler can override the state. Tier one is ignored. Tier two forces an escalate state. Tier three forces a terminal scrap state that cuts nearly every enable. An escalation stays in force until the next reset.

A transition request to a higher state runs a fixed sequence. First a clock-bypass handshake. Then, only for a move to RMA, a flash RMA handshake. Last, a program request to the memory controller. A successful program reply updates the stored state and the counter, but the enables keep decoding the state loaded at boot until the next reset. An error reply raises a one-cycle alert. A small read port exposes the effective state, the stored state, the counter and status.

Top module: `lc_esc_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, every enable output, every request output and alert_o are low. On the first edge after release, the block loads otp_state_i as both boot state and stored state, and loads otp_cnt_i as the counter.
- R2: State codes are RAW=0, TEST_UNLOCKED=1, TEST_LOCKED=2, DEV=3, PROD=4, RMA=5, ESCALATE=6, SCRAP=7. The boot state decodes to enables as follows:
  - dft and nvm_dbg in states 1 and 5.
  - hw_dbg in states 1, 3 and 5.
  - cpu in states 1 to 5.
  - keymgr, seed_rd and iso_rd in states 3, 4 and 5.
  - seed_rw in states 3 and 5.
  - iso_wr in states 1, 3, 4 and 5.
  - Codes 0, 6 and 7 enable none of them.
- R3: An esc_tier_i value of 1 has no effect on any output or on the read port.
- R4: esc_tier_i = 2, sampled on an edge, sets escalate_en_o and check_byp_en_o from that edge on. Read address 0 then returns 6, and the other enables keep decoding the boot state.
- R5: esc_tier_i = 3, sampled on an edge, selects scrap from that edge on. Read address 0 returns 7, escalate_en_o and check_byp_en_o are high, and every other enable, cpu_en_o included, is low. A boot state of 7, or of 6, also yields scrap or escalate behaviour.
- R6: Escalate and scrap are sticky until reset. A lower tier, or a tier of 0, never restores an earlier state.
- R7: A request (trans_req_i high on an edge) is accepted only when all of these hold: the block is idle and initialised, no escalation is active, and trans_target_i is greater than the stored state and at most 5. Any other request is ignored.
- R8: An accepted request raises clk_byp_req_o and holds it until clk_byp_ack_i is sampled. If the target is 5, flash_rma_req_o is then raised and held until flash_rma_ack_i. Then prog_req_o is held until prog_ack_i or prog_err_i, with prog_state_o equal to the target and prog_cnt_o equal to the counter plus one, modulo 2^CNT_W. At most one request line is high at a time.
- R9: check_byp_en_o is high whenever a transition is in progress, and whenever escalation is active.
- R10: prog_ack_i sets the stored state to the target and increments the counter. The enables and read address 0 are unchanged until reset, and after reset they follow the reloaded state.
- R11: prog_err_i (which wins over prog_ack_i) ends the transition without any update. It raises alert_o for exactly the following cycle and sets the sticky error status bit.
- R12: An escalation active while a transition is in progress drops every request one cycle after escalate_en_o rises, without an update. No request is accepted while escalate or scrap is active.
- R13: The read port, rd_data_o, is zero-extended. Address 0 returns the effective state, 1 the stored state, 2 the counter, and 3 returns {error status bit 1, busy bit 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| otp_state_i | input | 3 | Lifecycle state held in non-volatile memory |
| otp_cnt_i | input | CNT_W | Transition counter held in non-volatile memory |
| esc_tier_i | input | 2 | Escalation tier from the alert handler, 0 to 3 |
| trans_req_i | input | 1 | Transition request strobe |
| trans_target_i | input | 3 | Requested target state |
| prog_req_o | output | 1 | Program request to the memory controller |
| prog_state_o | output | 3 | State to program |
| prog_cnt_o | output | CNT_W | Counter value to program |
| prog_ack_i | input | 1 | Program done |
| prog_err_i | input | 1 | Program rejected |
| clk_byp_req_o | output | 1 | Clock bypass request |
| clk_byp_ack_i | input | 1 | Clock bypass acknowledge |
| flash_rma_req_o | output | 1 | Flash RMA request |
| flash_rma_ack_i | input | 1 | Flash RMA acknowledge |
| alert_o | output | 1 | One-cycle alert on program error |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | RD_W | Read data |
| dft_en_o | output | 1 | Test-mode enable |
| nvm_dbg_en_o | output | 1 | Flash debug enable |
| hw_dbg_en_o | output | 1 | Hardware debug enable |
| cpu_en_o | output | 1 | CPU fetch enable |
| keymgr_en_o | output | 1 | Key manager enable |
| seed_rw_en_o | output | 1 | Software seed read/write enable |
| seed_rd_en_o | output | 1 | Hardware seed read enable |
| iso_rd_en_o | output | 1 | Isolated partition read enable |
| iso_wr_en_o | output | 1 | Isolated partition write enable |
| escalate_en_o | output | 1 | Escalation enable |
| check_byp_en_o | output | 1 | Consistency check bypass enable |

## Verification
The hardest situation to reach from the ports is an escalation arriving while a transition handshake is still open. The bench starts a transition, withholds clk_byp_acknowledge, and raises the tier in the middle of the wait, so that the abort path and the one-cycle delay of the request drop are both seen. The counter-overflow error is also hard to reach, because the counter comes only from the memory side. The bench therefore preloads its memory model with the maximum count across a reset, and then answers the program request with an error. The deferred effect of a successful program is shown by reading the enables before and after a reset that reloads the new state.

// File: rtl/lc_esc_pkg.sv
package lc_esc_pkg;

  typedef enum logic [2:0] {
    LC_RAW       = 3'd0,
    LC_TEST_UNLK = 3'd1,
    LC_TEST_LCK  = 3'd2,
    LC_DEV       = 3'd3,
    LC_PROD      = 3'd4,
    LC_RMA       = 3'd5,
    LC_ESCAL     = 3'd6,
    LC_SCRAP     = 3'd7
  } lc_state_e;

  typedef enum logic [1:0] {
    ESC_NONE  = 2'd0,
    ESC_ESCAL = 2'd1,
    ESC_SCRAP = 2'd2
  } esc_lvl_e;

  typedef enum logic [1:0] {
    TR_IDLE      = 2'd0,
    TR_CLK_BYP   = 2'd1,
    TR_FLASH_RMA = 2'd2,
    TR_PROG      = 2'd3
  } tr_state_e;

  localparam logic [1:0] TIER_ESCAL = 2'd2;
  localparam logic [1:0] TIER_SCRAP = 2'd3;

  localparam int unsigned NUM_BCAST = 9;

  typedef struct packed {
    logic dft;
    logic nvm_dbg;
    logic hw_dbg;
    logic cpu;
    logic keymgr;
    logic seed_rw;
    logic seed_rd;
    logic iso_rd;
    logic iso_wr;
  } bcast_t;

endpackage

// File: rtl/lc_esc_tracker.sv
module lc_esc_tracker
  import lc_esc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] tier_i,
  output esc_lvl_e   lvl_o
);

  esc_lvl_e lvl_q, lvl_d;

  // tier 1 deliberately falls through: no effect
  always_comb begin
    lvl_d = lvl_q;
    if (tier_i == TIER_SCRAP) lvl_d = ESC_SCRAP;
    else if (tier_i == TIER_ESCAL && lvl_q == ESC_NONE) lvl_d = ESC_ESCAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= ESC_NONE;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  a_r3_tier1_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == ESC_NONE && tier_i == 2'd1) |=> lvl_q == ESC_NONE);

  a_r6_scrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q == ESC_SCRAP |=> lvl_q == ESC_SCRAP);

  a_r6_escal_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q != ESC_NONE |=> lvl_q != ESC_NONE);

endmodule

// File: rtl/lc_trans_seq.sv
module lc_trans_seq
  import lc_esc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  lc_state_e target_i,
  input  logic      abort_i,
  input  logic      clk_byp_ack_i,
  input  logic      flash_rma_ack_i,
  input  logic      prog_ack_i,
  input  logic      prog_err_i,
  output logic      clk_byp_req_o,
  output logic      flash_rma_req_o,
  output logic      prog_req_o,
  output lc_state_e target_o,
  output logic      busy_o,
  output logic      commit_o,
  output logic      fail_o
);

  tr_state_e st_q, st_d;
  lc_state_e tgt_q;

  always_comb begin
    st_d     = st_q;
    commit_o = 1'b0;
    fail_o   = 1'b0;
    unique case (st_q)
      TR_IDLE: if (start_i) st_d = TR_CLK_BYP;
      TR_CLK_BYP: begin
        if (abort_i)            st_d = TR_IDLE;
        else if (clk_byp_ack_i) st_d = (tgt_q == LC_RMA) ? TR_FLASH_RMA : TR_PROG;
      end
      TR_FLASH_RMA: begin
        if (abort_i)              st_d = TR_IDLE;
        else if (flash_rma_ack_i) st_d = TR_PROG;
      end
      TR_PROG: begin
        if (abort_i) st_d = TR_IDLE;
        else if (prog_err_i) begin
          st_d   = TR_IDLE;
          fail_o = 1'b1;
        end else if (prog_ack_i) begin
          st_d     = TR_IDLE;
          commit_o = 1'b1;
        end
      end
      default: st_d = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TR_IDLE;
      tgt_q <= LC_RAW;
    end else begin
      st_q <= st_d;
      if (st_q == TR_IDLE && start_i) tgt_q <= target_i;
    end
  end

  assign clk_byp_req_o   = (st_q == TR_CLK_BYP);
  assign flash_rma_req_o = (st_q == TR_FLASH_RMA);
  assign prog_req_o      = (st_q == TR_PROG);
  assign busy_o          = (st_q != TR_IDLE);
  assign target_o        = tgt_q;

  a_r8_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clk_byp_req_o, flash_rma_req_o, prog_req_o}));

  a_r8_clk_byp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_byp_req_o && !clk_byp_ack_i && !abort_i) |=> clk_byp_req_o);

  a_r8_rma_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_rma_req_o && !flash_rma_ack_i && !abort_i) |=> flash_rma_req_o);

  a_r8_prog_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o && !prog_ack_i && !prog_err_i && !abort_i) |=> prog_req_o);

  a_r12_abort_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> !busy_o);

endmodule

// File: rtl/lc_bcast_decode.sv
module lc_bcast_decode
  import lc_esc_pkg::*;
(
  input  lc_state_e state_i,
  input  logic      en_i,
  output bcast_t    bcast_o
);

  // bit s of each mask: enable is on in state code s; index 0 is the struct LSB (iso_wr)
  localparam logic [7:0] STATE_MASK [NUM_BCAST] = '{
    8'h3A,  // iso_wr
    8'h38,  // iso_rd
    8'h38,  // seed_rd
    8'h28,  // seed_rw
    8'h38,  // keymgr
    8'h3E,  // cpu
    8'h2A,  // hw_dbg
    8'h22,  // nvm_dbg
    8'h22   // dft
  };

  logic [NUM_BCAST-1:0] vec;

  for (genvar gi = 0; gi < NUM_BCAST; gi++) begin : g_bit
    assign vec[gi] = en_i & STATE_MASK[gi][state_i];
  end

  assign bcast_o = bcast_t'(vec);

endmodule

// File: rtl/lc_esc_ctrl.sv
module lc_esc_ctrl
  import lc_esc_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned RD_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       otp_state_i,
  input  logic [CNT_W-1:0] otp_cnt_i,
  input  logic [1:0]       esc_tier_i,
  input  logic             trans_req_i,
  input  logic [2:0]       trans_target_i,
  output logic             prog_req_o,
  output logic [2:0]       prog_state_o,
  output logic [CNT_W-1:0] prog_cnt_o,
  input  logic             prog_ack_i,
  input  logic             prog_err_i,
  output logic             clk_byp_req_o,
  input  logic             clk_byp_ack_i,
  output logic             flash_rma_req_o,
  input  logic             flash_rma_ack_i,
  output logic             alert_o,
  input  logic [1:0]       rd_addr_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic             dft_en_o,
  output logic             nvm_dbg_en_o,
  output logic             hw_dbg_en_o,
  output logic             cpu_en_o,
  output logic             keymgr_en_o,
  output logic             seed_rw_en_o,
  output logic             seed_rd_en_o,
  output logic             iso_rd_en_o,
  output logic             iso_wr_en_o,
  output logic             escalate_en_o,
  output logic             check_byp_en_o
);

  localparam int unsigned ST_PAD  = RD_W - 3;
  localparam int unsigned CNT_PAD = RD_W - CNT_W;
  localparam int unsigned STS_PAD = RD_W - 2;

  logic             init_q, err_q, alert_q;
  lc_state_e        boot_q, stored_q, eff_state;
  logic [CNT_W-1:0] cnt_q;
  esc_lvl_e         esc_lvl;
  logic             busy, commit, fail, accept, scrap;
  lc_state_e        seq_tgt;
  bcast_t           bcast;

  lc_esc_tracker u_tracker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tier_i (esc_tier_i),
    .lvl_o  (esc_lvl)
  );

  always_comb begin
    unique case (esc_lvl)
      ESC_SCRAP: eff_state = LC_SCRAP;
      ESC_ESCAL: eff_state = (boot_q == LC_SCRAP) ? LC_SCRAP : LC_ESCAL;
      default:   eff_state = boot_q;
    endcase
  end

  assign scrap         = (eff_state == LC_SCRAP);
  assign escalate_en_o = init_q && (eff_state == LC_ESCAL || eff_state == LC_SCRAP);
  assign check_byp_en_o = escalate_en_o || busy;

  assign accept = init_q && !escalate_en_o && !busy && trans_req_i &&
                  (trans_target_i > stored_q) && (trans_target_i <= LC_RMA);

  lc_trans_seq u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (accept),
    .target_i        (lc_state_e'(trans_target_i)),
    .abort_i         (esc_lvl != ESC_NONE),
    .clk_byp_ack_i   (clk_byp_ack_i),
    .flash_rma_ack_i (flash_rma_ack_i),
    .prog_ack_i      (prog_ack_i),
    .prog_err_i      (prog_err_i),
    .clk_byp_req_o   (clk_byp_req_o),
    .flash_rma_req_o (flash_rma_req_o),
    .prog_req_o      (prog_req_o),
    .target_o        (seq_tgt),
    .busy_o          (busy),
    .commit_o        (commit),
    .fail_o          (fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= 1'b0;
      boot_q   <= LC_RAW;
      stored_q <= LC_RAW;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      alert_q  <= 1'b0;
    end else begin
      alert_q <= fail;
      if (fail) err_q <= 1'b1;
      if (!init_q) begin
        init_q   <= 1'b1;
        boot_q   <= lc_state_e'(otp_state_i);
        stored_q <= lc_state_e'(otp_state_i);
        cnt_q    <= otp_cnt_i;
      end else if (commit) begin
        // takes effect on outputs only after the state is reloaded at reset
        stored_q <= seq_tgt;
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign alert_o      = alert_q;
  assign prog_state_o = seq_tgt;
  assign prog_cnt_o   = cnt_q + 1'b1;

  lc_bcast_decode u_decode (
    .state_i (boot_q),
    .en_i    (init_q && !scrap),
    .bcast_o (bcast)
  );

  assign dft_en_o     = bcast.dft;
  assign nvm_dbg_en_o = bcast.nvm_dbg;
  assign hw_dbg_en_o  = bcast.hw_dbg;
  assign cpu_en_o     = bcast.cpu;
  assign keymgr_en_o  = bcast.keymgr;
  assign seed_rw_en_o = bcast.seed_rw;
  assign seed_rd_en_o = bcast.seed_rd;
  assign iso_rd_en_o  = bcast.iso_rd;
  assign iso_wr_en_o  = bcast.iso_wr;

  always_comb begin
    unique case (rd_addr_i)
      2'd0:    rd_data_o = {{ST_PAD{1'b0}}, eff_state};
      2'd1:    rd_data_o = {{ST_PAD{1'b0}}, stored_q};
      2'd2:    rd_data_o = {{CNT_PAD{1'b0}}, cnt_q};
      default: rd_data_o = {{STS_PAD{1'b0}}, err_q, busy};
    endcase
  end

  a_r9_chk_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> check_byp_en_o);

  a_r11_alert_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> !alert_o);

  a_r5_scrap_cuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_lvl == ESC_SCRAP) |-> (!cpu_en_o && !dft_en_o && !hw_dbg_en_o &&
                                !keymgr_en_o && escalate_en_o && check_byp_en_o));

  a_r10_enables_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> $stable({dft_en_o, hw_dbg_en_o, cpu_en_o, keymgr_en_o, iso_wr_en_o}));

  a_r12_no_start_escal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && escalate_en_o) |=> !busy);

  a_r1_quiet_before_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |-> !(cpu_en_o || escalate_en_o || clk_byp_req_o || prog_req_o || alert_o));

endmodule

// File: tb/tb_lc_esc_ctrl.sv
module tb_lc_esc_ctrl;

  localparam int CNT_W = 4;
  localparam int RD_W  = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int nvm_state = 0;
  int nvm_cnt   = 0;
  logic [1:0] esc_tier = '0;
  logic trans_req = 1'b0;
  logic [2:0] trans_tgt = '0;
  logic prog_ack = 1'b0, prog_err = 1'b0, clk_byp_ack = 1'b0, rma_ack = 1'b0;
  logic [1:0] rd_addr = '0;

  logic prog_req, clk_byp_req, rma_req, alert;
  logic [2:0] prog_state;
  logic [CNT_W-1:0] prog_cnt;
  logic [RD_W-1:0] rd_data;
  logic dft, nvm_dbg, hw_dbg, cpu, keymgr, seed_rw, seed_rd, iso_rd, iso_wr, esc_en, chk_byp;

  lc_esc_ctrl #(.CNT_W(CNT_W), .RD_W(RD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .otp_state_i(3'(nvm_state)), .otp_cnt_i(CNT_W'(nvm_cnt)),
    .esc_tier_i(esc_tier), .trans_req_i(trans_req), .trans_target_i(trans_tgt),
    .prog_req_o(prog_req), .prog_state_o(prog_state), .prog_cnt_o(prog_cnt),
    .prog_ack_i(prog_ack), .prog_err_i(prog_err),
    .clk_byp_req_o(clk_byp_req), .clk_byp_ack_i(clk_byp_ack),
    .flash_rma_req_o(rma_req), .flash_rma_ack_i(rma_ack),
    .alert_o(alert), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dft_en_o(dft), .nvm_dbg_en_o(nvm_dbg), .hw_dbg_en_o(hw_dbg), .cpu_en_o(cpu),
    .keymgr_en_o(keymgr), .seed_rw_en_o(seed_rw), .seed_rd_en_o(seed_rd),
    .iso_rd_en_o(iso_rd), .iso_wr_en_o(iso_wr),
    .escalate_en_o(esc_en), .check_byp_en_o(chk_byp)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // enable order: dft nvm_dbg hw_dbg cpu keymgr seed_rw seed_rd iso_rd iso_wr (R2 table)
  function automatic int dec(input int s);
    case (s)
      1: return 9'b111_100_001;
      2: return 9'b000_100_000;
      3: return 9'b001_111_111;
      4: return 9'b000_110_111;
      5: return 9'b111_111_111;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model
  int m_init, m_base, m_stored, m_cnt, m_esc, m_fsm, m_tgt, m_alert, m_err;

  function automatic int m_eff();
    if (m_esc == 2) return 7;
    if (m_esc == 1) return (m_base == 7) ? 7 : 6;
    return m_base;
  endfunction

  function automatic bit m_esc_on();
    return m_init != 0 && m_eff() >= 6;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 0; m_base = 0; m_stored = 0; m_cnt = 0; m_esc = 0;
      m_fsm = 0; m_tgt = 0; m_alert = 0; m_err = 0;
    end else begin
      int nf;
      bit cm, fl;
      nf = m_fsm; cm = 0; fl = 0;
      case (m_fsm)
        0: if (m_init != 0 && !m_esc_on() && trans_req && int'(trans_tgt) > m_stored && trans_tgt <= 5) begin
             nf = 1; m_tgt = trans_tgt;
           end
        1: if (m_esc != 0) nf = 0; else if (clk_byp_ack) nf = (m_tgt == 5) ? 2 : 3;
        2: if (m_esc != 0) nf = 0; else if (rma_ack) nf = 3;
        3: if (m_esc != 0) nf = 0;
           else if (prog_err) begin nf = 0; fl = 1; end
           else if (prog_ack) begin nf = 0; cm = 1; end
        default: nf = 0;
      endcase
      m_alert = fl;
      if (fl) m_err = 1;
      if (cm) begin m_stored = m_tgt; m_cnt = (m_cnt + 1) % (CMAX + 1); end
      if (m_init == 0) begin m_init = 1; m_base = nvm_state; m_stored = nvm_state; m_cnt = nvm_cnt; end
      if (esc_tier == 2'd3) m_esc = 2;
      else if (esc_tier == 2'd2 && m_esc == 0) m_esc = 1;
      m_fsm = nf;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int e_bc, e_rd;
    bit e_esc;
    e_esc = m_esc_on();
    e_bc  = (m_init != 0 && m_eff() != 7) ? dec(m_base) : 0;
    check("R2 enables", int'({dft, nvm_dbg, hw_dbg, cpu, keymgr, seed_rw, seed_rd, iso_rd, iso_wr}), e_bc);
    check("R4 escalate_en", int'(esc_en), int'(e_esc));
    check("R9 check_byp_en", int'(chk_byp), int'(e_esc || m_fsm != 0));
    check("R8 requests", int'({clk_byp_req, rma_req, prog_req}),
          (m_fsm == 1) ? 4 : (m_fsm == 2) ? 2 : (m_fsm == 3) ? 1 : 0);
    if (prog_req) begin
      check("R8 prog_state", int'(prog_state), m_tgt);
      check("R8 prog_cnt", int'(prog_cnt), (m_cnt + 1) % (CMAX + 1));
    end
    check("R11 alert", int'(alert), m_alert);
    case (rd_addr)
      2'd0: e_rd = m_eff();
      2'd1: e_rd = m_stored;
      2'd2: e_rd = m_cnt;
      default: e_rd = m_err * 2 + ((m_fsm != 0) ? 1 : 0);
    endcase
    check("R13 rd_data", int'(rd_data), e_rd);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic do_reset(input int s, input int c);
    nvm_state = s; nvm_cnt = c;
    esc_tier = '0;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic request(input int t);
    trans_tgt = 3'(t);
    trans_req = 1'b1;
    cyc(1);
    trans_req = 1'b0;
  endtask

  task automatic ack_clk();
    while (!clk_byp_req) @(negedge clk);
    @(posedge clk); #2 clk_byp_ack = 1'b1;
    @(posedge clk); #2 clk_byp_ack = 1'b0;
  endtask

  task automatic ack_rma();
    while (!rma_req) @(negedge clk);
    @(posedge clk); #2 rma_ack = 1'b1;
    @(posedge clk); #2 rma_ack = 1'b0;
  endtask

  // memory model: rejects when its counter is already at the maximum
  task automatic serve_prog();
    while (!prog_req) @(negedge clk);
    @(posedge clk); #2;
    if (nvm_cnt == CMAX) prog_err = 1'b1;
    else begin
      prog_ack = 1'b1;
      nvm_state = int'(prog_state);
      nvm_cnt = int'(prog_cnt);
    end
    @(posedge clk); #2;
    prog_ack = 1'b0; prog_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    // R1: quiet in reset and during the load cycle
    nvm_state = 3; nvm_cnt = 2;
    cyc(3);
    check("R1 in reset", int'({cpu, esc_en, clk_byp_req, prog_req, alert, hw_dbg}), 0);
    rst_n = 1'b1;
    #1;
    check("R1 before load", int'({cpu, hw_dbg, keymgr}), 0);
    cyc(2);
    check("R2 DEV hw_dbg", int'(hw_dbg), 1);
    check("R2 DEV dft", int'(dft), 0);
    rd(2'd0, v); check("R13 state DEV", v, 3);
    rd(2'd2, v); check("R13 count", v, 2);

    // R3: tier 1 inert
    esc_tier = 2'd1;
    cyc(5);
    check("R3 escalate_en", int'(esc_en), 0);
    rd(2'd0, v); check("R3 state", v, 3);
    esc_tier = 2'd0;

    // R8/R9/R10: DEV -> PROD
    request(4);
    check("R8 clk_byp_req", int'(clk_byp_req), 1);
    check("R9 check_byp busy", int'(chk_byp), 1);
    ack_clk();
    check("R8 no rma for PROD", int'(rma_req), 0);
    check("R8 prog_req", int'(prog_req), 1);
    check("R8 prog_state", int'(prog_state), 4);
    check("R8 prog_cnt", int'(prog_cnt), 3);
    serve_prog();
    rd(2'd3, v); check("R13 idle status", v, 0);
    rd(2'd1, v); check("R10 stored", v, 4);
    rd(2'd2, v); check("R10 count", v, 3);
    rd(2'd0, v); check("R10 active unchanged", v, 3);
    check("R10 hw_dbg still DEV", int'(hw_dbg), 1);
    do_reset(nvm_state, nvm_cnt);
    check("R10 hw_dbg after reset", int'(hw_dbg), 0);
    rd(2'd0, v); check("R10 active after reset", v, 4);

    // R7: illegal targets ignored
    request(2);
    check("R7 lower target", int'(clk_byp_req), 0);
    request(4);
    check("R7 same target", int'(clk_byp_req), 0);
    request(6);
    rd(2'd3, v); check("R7 escalate target", v, 0);

    // R8/R11: to RMA with counter at max
    do_reset(1, CMAX);
    request(5);
    ack_clk();
    check("R8 rma_req", int'(rma_req), 1);
    ack_rma();
    check("R8 prog after rma", int'(prog_req), 1);
    check("R8 prog_cnt wrap", int'(prog_cnt), 0);
    serve_prog();
    check("R11 alert high", int'(alert), 1);
    cyc(1);
    check("R11 alert one cycle", int'(alert), 0);
    rd(2'd3, v); check("R11 err status", v, 2);
    rd(2'd1, v); check("R11 no commit state", v, 1);
    rd(2'd2, v); check("R11 no commit count", v, CMAX);

    // R4/R12/R6/R5: escalation during a handshake
    do_reset(1, 3);
    request(3);
    esc_tier = 2'd2;
    cyc(1);
    check("R4 escalate_en", int'(esc_en), 1);
    check("R4 check_byp", int'(chk_byp), 1);
    cyc(1);
    check("R12 request dropped", int'(clk_byp_req), 0);
    rd(2'd0, v); check("R4 state escalate", v, 6);
    check("R4 dft kept", int'(dft), 1);
    request(5);
    cyc(1);
    rd(2'd3, v); check("R12 no new request", v, 0);
    rd(2'd1, v); check("R12 no update", v, 1);
    esc_tier = 2'd0;
    cyc(3);
    check("R6 escalate sticky", int'(esc_en), 1);
    esc_tier = 2'd3;
    cyc(1);
    rd(2'd0, v); check("R5 state scrap", v, 7);
    check("R5 cpu off", int'(cpu), 0);
    check("R5 others off", int'({dft, nvm_dbg, hw_dbg, keymgr, seed_rw, seed_rd, iso_rd, iso_wr}), 0);
    check("R5 escalate_en", int'(esc_en), 1);
    check("R5 check_byp", int'(chk_byp), 1);
    esc_tier = 2'd1;
    cyc(3);
    rd(2'd0, v); check("R6 scrap sticky", v, 7);

    // R2: every boot code
    for (int s = 0; s < 8; s++) begin
      do_reset(s, 0);
      rd(2'd0, v); check("R2 boot code", v, s);
      check("R2 decode", int'({dft, nvm_dbg, hw_dbg, cpu, keymgr, seed_rw, seed_rd, iso_rd, iso_wr}), dec(s));
      check("R5 boot escalate", int'(esc_en), (s >= 6) ? 1 : 0);
    end

    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule